// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter

This block is a 16-bit up-counter that shares one count register between five ways of working: a free-running timer, a timer that waits for an edge on an external pin before it starts, a gated counter that counts only while the pin is high, a pulse-width meter, and a pulse generator whose duty cycle is set by two compare values. A pre-divided source-clock enable sets the counting rate. The mode, the trigger polarity, the run command and a software capture request come in as plain ports, so a register file elsewhere in the chip can drive them directly.

Compare register A sets the period in every counting mode. Register B has two jobs: it is the second compare point of the pulse generator, and it receives captured counts, either at the end of a measured pulse or when software asks for a snapshot. The external pin is asynchronous. It passes through a synchroniser before any edge is taken from it. Every match or completed measurement raises a one-cycle interrupt pulse.

Top module: `tmr16_multi`

## Requirements
- R1: While reset is asserted and after it is released, `irq` is 0, `ppg_out` is 0 and `reg_b` is 0.
- R2: In mode code 0 (free timer), the counter advances by one on each cycle with `src_en` high. If it equals `cmp_a` on an enable, it goes to zero instead, which gives a period of `cmp_a`+1 enables. It does not change on cycles without an enable.
- R3: `irq` is high for exactly one clock cycle per event. It rises in the cycle after the enable that hit `cmp_a`, or after the cycle in which a measured pulse ended.
- R4: In mode code 1 (triggered timer), the counter holds at zero until a trigger edge arms it. The trigger is a rising pin edge when `edge_fall`=0 and a falling pin edge when `edge_fall`=1. Edges of the other polarity are ignored. Once armed, it counts as in R2.
- R5: In mode code 2 (window), the counter advances only on enables during which the synchronised pin is high. Matching and wrapping work as in R2.
- R6: In mode code 3 (pulse width), the trigger edge arms the counter, which then counts enables. On the opposite edge, the count is copied into `reg_b`, `irq` pulses, the counter clears and the block waits for the next trigger edge.
- R7: In mode code 4 (pulse generator), counting starts on the trigger edge. `ppg_out` inverts on an enable where the count equals `reg_b`, and inverts again on an enable where it equals `cmp_a` (the counter then clears). This gives a high time of `cmp_a`-`reg_b` enables in a period of `cmp_a`+1.
- R8: A one-cycle `cap_req` pulse copies the counter into `reg_b` on the first `src_en` cycle after the cycle of the request, never earlier.
- R9: When `start` is low, when `mode_sel` differs from its value in the previous cycle, or when an unused mode code (5 to 7) is selected, the counter is held at zero and disarmed. In the first two cases `ppg_out` also takes the value of `idle_lvl`.
- R10: The pin passes through two flip-flops before edge detection. A trigger edge applied before clock edge 1 arms the counter at clock edge 3.
- R11: A `b_load` cycle writes `b_load_val` into `reg_b`. This takes priority over any capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Source-clock enable, one count step per high cycle |
| pin_in | input | 1 | Asynchronous external pin |
| mode_sel | input | 3 | 0 free, 1 triggered, 2 window, 3 pulse width, 4 pulse generator |
| edge_fall | input | 1 | Trigger polarity: 0 rising, 1 falling |
| start | input | 1 | Run command; low stops and clears |
| cap_req | input | 1 | Software capture request pulse |
| idle_lvl | input | 1 | Level of `ppg_out` while stopped |
| cmp_a | input | 16 | Compare value A (period) |
| b_load | input | 1 | Write strobe for register B |
| b_load_val | input | 16 | Value written into register B |
| irq | output | 1 | One-cycle interrupt pulse |
| ppg_out | output | 1 | Pulse-generator output |
| reg_b | output | 16 | Register B: compare value and capture result |

## Verification
On every cycle, the embedded properties check several things. The count is frozen on cycles with no enable. The window gate blocks counting while the pin is low. A stop clears the count and returns the generator output to its idle level. Register B changes only after a load, an enable or a pulse end. An interrupt always follows an enable or a measurement end. The bench scenarios are the only check on the exact number of cycles from the pin to arming, the captured widths, the generator's duty cycle and the delay of a software snapshot. They do this by comparing a behavioural model on every cycle, under both dense and sparse enable patterns.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MD_FREE = 3'd0,
      MD_TRIG = 3'd1,
      MD_WIN  = 3'd2,
      MD_MEAS = 3'd3,
      MD_PPG  = 3'd4
   } tmr_mode_e;
endpackage

// File: rtl/tmr16_pin_sync.sv
module tmr16_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   input  logic fall_sel,
   output logic lvl,
   output logic go_edge,
   output logic end_edge
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr16_pin_sync: STAGES must be at least 2");
   end

   logic [TOP:0] chain;
   logic         last;
   logic         rise, fall;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= pin_async;
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= 1'b0;
      else        last <= chain[TOP];

   assign lvl      = chain[TOP];
   assign rise     = chain[TOP] & ~last;
   assign fall     = ~chain[TOP] & last;
   assign go_edge  = fall_sel ? fall : rise;
   assign end_edge = fall_sel ? rise : fall;

   AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      go_edge |=> !go_edge); // R10
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
   import tmr16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_en,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic              lvl,
   input  logic              go_edge,
   input  logic              end_edge,
   input  logic [WIDTH-1:0]  cmp_a,
   input  logic [WIDTH-1:0]  cmp_b,
   input  logic              idle_lvl,
   output logic [WIDTH-1:0]  cnt,
   output logic              irq,
   output logic              ppg,
   output logic              meas_cap
);
   logic [MODE_W-1:0] mode_q;
   logic              armed;
   logic              run_ok;
   logic              a_hit, b_hit;
   logic [WIDTH-1:0]  cnt_step;

   assign run_ok   = start && (mode == mode_q);
   assign a_hit    = (cnt == cmp_a);
   assign b_hit    = (cnt == cmp_b);
   assign cnt_step = a_hit ? '0 : cnt + 1'b1;
   assign meas_cap = run_ok && (mode == MD_MEAS) && armed && end_edge;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mode_q <= '0;
      else        mode_q <= mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
         irq   <= 1'b0;
         ppg   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (!run_ok) begin
            cnt   <= '0;
            armed <= 1'b0;
            ppg   <= idle_lvl;
         end else begin
            case (mode)
               MD_FREE, MD_WIN: begin
                  if (src_en && ((mode == MD_FREE) || lvl)) begin
                     cnt <= cnt_step;
                     irq <= a_hit;
                  end
               end
               MD_TRIG, MD_PPG: begin
                  if (!armed) begin
                     armed <= go_edge;
                  end else if (src_en) begin
                     cnt <= cnt_step;
                     irq <= a_hit;
                     if (mode == MD_PPG) ppg <= ppg ^ a_hit ^ b_hit;
                  end
               end
               MD_MEAS: begin
                  if (!armed) begin
                     armed <= go_edge;
                  end else if (end_edge) begin
                     cnt   <= '0;
                     armed <= 1'b0;
                     irq   <= 1'b1;
                  end else if (src_en) begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  cnt   <= '0;
                  armed <= 1'b0;
               end
            endcase
         end
      end
   end

   AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ok && !src_en && !meas_cap) |=> (cnt == $past(cnt))); // R2
   AST_WIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_ok && (mode == MD_WIN) && !lvl) |=> (cnt == $past(cnt))); // R5
   AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ((cnt == '0) && (ppg == $past(idle_lvl)))); // R9
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(src_en) || $past(meas_cap))); // R3
endmodule

// File: rtl/tmr16_capture.sv
module tmr16_capture #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_en,
   input  logic             cap_req,
   input  logic             meas_cap,
   input  logic [WIDTH-1:0] cnt,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] reg_b
);
   logic pend;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pend <= 1'b0;
      else        pend <= cap_req | (pend & ~src_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               reg_b <= '0;
      else if (load)            reg_b <= load_val;
      else if (meas_cap)        reg_b <= cnt;
      else if (pend && src_en)  reg_b <= cnt;
   end

   AST_B_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_b) |-> $past(src_en || meas_cap || load)); // R8
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
   import tmr16_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_en,
   input  logic              pin_in,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              edge_fall,
   input  logic              start,
   input  logic              cap_req,
   input  logic              idle_lvl,
   input  logic [WIDTH-1:0]  cmp_a,
   input  logic              b_load,
   input  logic [WIDTH-1:0]  b_load_val,
   output logic              irq,
   output logic              ppg_out,
   output logic [WIDTH-1:0]  reg_b
);
   if (WIDTH < 2) begin : g_bad_width
      $error("tmr16_multi: WIDTH must be at least 2");
   end

   logic             lvl, go_edge, end_edge, meas_cap;
   logic [WIDTH-1:0] cnt;

   tmr16_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_async(pin_in),
      .fall_sel (edge_fall),
      .lvl      (lvl),
      .go_edge  (go_edge),
      .end_edge (end_edge)
   );

   tmr16_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_en  (src_en),
      .start   (start),
      .mode    (mode_sel),
      .lvl     (lvl),
      .go_edge (go_edge),
      .end_edge(end_edge),
      .cmp_a   (cmp_a),
      .cmp_b   (reg_b),
      .idle_lvl(idle_lvl),
      .cnt     (cnt),
      .irq     (irq),
      .ppg     (ppg_out),
      .meas_cap(meas_cap)
   );

   tmr16_capture #(.WIDTH(WIDTH)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_en  (src_en),
      .cap_req (cap_req),
      .meas_cap(meas_cap),
      .cnt     (cnt),
      .load    (b_load),
      .load_val(b_load_val),
      .reg_b   (reg_b)
   );
endmodule

// File: tb/tmr16_multi_tb.sv
module tmr16_multi_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, src_en, pin_in, edge_fall, start, cap_req, idle_lvl, b_load;
   logic [2:0]  mode_sel;
   logic [15:0] cmp_a, b_load_val;
   logic        irq, ppg_out;
   logic [15:0] reg_b;

   tmr16_multi u_dut (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .pin_in(pin_in),
      .mode_sel(mode_sel), .edge_fall(edge_fall), .start(start),
      .cap_req(cap_req), .idle_lvl(idle_lvl), .cmp_a(cmp_a),
      .b_load(b_load), .b_load_val(b_load_val),
      .irq(irq), .ppg_out(ppg_out), .reg_b(reg_b)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    vectors = 0, miscompares = 0;
   int    irq_seen = 0, irq_run = 0, irq_run_max = 0, ppg_hi = 0;
   string phase = "R1 reset";
   bit    en_sparse = 1'b0;
   int    en_k = 0;

   // enable pattern: every cycle, or one cycle in three
   always @(negedge clk) begin
      src_en = en_sparse ? ((en_k % 3) == 0) : 1'b1;
      en_k++;
   end

   // behavioural reference state
   logic        p1, p2, p3;
   logic [15:0] m_cnt, m_b, oc;
   logic        m_arm, m_irq, m_ppg, m_pend;
   logic [2:0]  m_modeq;
   bit          ge, ee, run, mc;

   task automatic advance();
      if (oc == cmp_a) begin m_cnt = 16'd0; m_irq = 1'b1; end
      else m_cnt = oc + 16'd1;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         p1 = 0; p2 = 0; p3 = 0; m_cnt = 0; m_arm = 0; m_irq = 0;
         m_ppg = 0; m_b = 0; m_pend = 0; m_modeq = 0;
      end else begin
         ge  = edge_fall ? (!p2 && p3) : (p2 && !p3);
         ee  = edge_fall ? (p2 && !p3) : (!p2 && p3);
         oc  = m_cnt;
         run = start && (mode_sel == m_modeq);
         m_modeq = mode_sel;
         mc  = run && (mode_sel == 3'd3) && m_arm && ee;
         if (b_load)                m_b = b_load_val;
         else if (mc)               m_b = oc;
         else if (m_pend && src_en) m_b = oc;
         m_pend = cap_req || (m_pend && !src_en);
         m_irq = 1'b0;
         if (!run) begin
            m_cnt = 0; m_arm = 0; m_ppg = idle_lvl;
         end else if (mode_sel == 3'd0 || mode_sel == 3'd2) begin
            if (src_en && (mode_sel == 3'd0 || p2)) advance();
         end else if (mode_sel == 3'd1 || mode_sel == 3'd4) begin
            if (!m_arm) m_arm = ge;
            else if (src_en) begin
               if (mode_sel == 3'd4) m_ppg = m_ppg ^ (oc == m_b_prev()) ^ (oc == cmp_a);
               advance();
            end
         end else if (mode_sel == 3'd3) begin
            if (!m_arm) m_arm = ge;
            else if (ee) begin m_cnt = 0; m_arm = 0; m_irq = 1'b1; end
            else if (src_en) m_cnt = oc + 16'd1;
         end else begin
            m_cnt = 0; m_arm = 0;
         end
         p3 = p2; p2 = p1; p1 = pin_in;
      end
      b_prev_q = m_b;
      #(CLK_PERIOD/4);
      if (rst_n) begin
         vectors++;
         if (irq !== m_irq || ppg_out !== m_ppg || reg_b !== m_b) begin
            miscompares++;
            $display("FAIL %s: irq/ppg/reg_b act %0b/%0b/%h exp %0b/%0b/%h",
                     phase, irq, ppg_out, reg_b, m_irq, m_ppg, m_b);
         end
         if (irq) begin irq_seen++; irq_run++; end else irq_run = 0;
         if (irq_run > irq_run_max) irq_run_max = irq_run;
         if (ppg_out) ppg_hi++;
      end
   end

   // register B as it stood before this edge's update (compare point of the generator)
   logic [15:0] b_prev_q = 16'd0;
   logic [15:0] b_before;
   always @(negedge clk) b_before = reg_b;
   function automatic logic [15:0] m_b_prev();
      return b_before;
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: act %0d exp %0d", tag, act, exp);
      end
   endtask

   task automatic ld_b(input logic [15:0] v);
      b_load_val = v; b_load = 1'b1; cyc(1); b_load = 1'b0;
   endtask

   task automatic snap();
      cap_req = 1'b1; cyc(1); cap_req = 1'b0; cyc(1);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog: act running exp finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; pin_in = 0; mode_sel = 0; edge_fall = 0; start = 0; cap_req = 0;
      idle_lvl = 0; cmp_a = 16'd4; b_load = 0; b_load_val = 0;
      cyc(3);
      rst_n = 1;
      chk(irq == 0 && ppg_out == 0 && reg_b == 0, "R1 reset values",
          {irq, ppg_out, reg_b}, 0);

      phase = "R11 load";
      ld_b(16'h1234);
      chk(reg_b == 16'h1234, "R11 load B", reg_b, 16'h1234);

      phase = "R2 R3 free";
      irq_seen = 0; irq_run_max = 0; start = 1;
      cyc(25);
      chk(irq_seen == 5, "R2 period A+1", irq_seen, 5);
      chk(irq_run_max == 1, "R3 single-cycle irq", irq_run_max, 1);

      phase = "R8 capture";
      start = 0; cmp_a = 16'd100; cyc(2);
      start = 1; cyc(7);
      cap_req = 1; cyc(1); cap_req = 0;
      chk(reg_b == 16'h1234, "R8 not before enable", reg_b, 16'h1234);
      cyc(1);
      chk(reg_b == 16'd8, "R8 snapshot", reg_b, 8);

      phase = "R9 mode change";
      mode_sel = 3'd2; cyc(4); snap();
      chk(reg_b == 16'd0, "R9 cleared on mode change", reg_b, 0);

      phase = "R5 window";
      start = 0; cyc(1);
      start = 1; pin_in = 1; cyc(5); pin_in = 0; cyc(6); snap();
      chk(reg_b == 16'd5, "R5 gated count", reg_b, 5);

      phase = "R4 R10 trigger rise";
      start = 0; mode_sel = 3'd1; cmp_a = 16'd3; edge_fall = 0; cyc(2);
      start = 1; irq_seen = 0; cyc(6);
      chk(irq_seen == 0, "R4 idle before trigger", irq_seen, 0);
      pin_in = 1; irq_seen = 0; cyc(20);
      chk(irq_seen == 4, "R4 R10 count after rise", irq_seen, 4);

      phase = "R4 trigger fall";
      start = 0; pin_in = 0; cyc(4);
      edge_fall = 1; start = 1; pin_in = 1; irq_seen = 0; cyc(10);
      chk(irq_seen == 0, "R4 rising ignored", irq_seen, 0);
      pin_in = 0; irq_seen = 0; cyc(20);
      chk(irq_seen == 4, "R4 count after fall", irq_seen, 4);

      phase = "R6 measure";
      start = 0; mode_sel = 3'd3; edge_fall = 0; cmp_a = 16'hFFFF; cyc(4);
      start = 1; cyc(2); irq_seen = 0;
      pin_in = 1; cyc(10); pin_in = 0; cyc(6);
      chk(reg_b == 16'd9, "R6 width captured", reg_b, 9);
      chk(irq_seen == 1, "R6 one irq", irq_seen, 1);

      phase = "R7 ppg";
      start = 0; mode_sel = 3'd4; idle_lvl = 0; cmp_a = 16'd5; pin_in = 0;
      ld_b(16'd2); cyc(4);
      chk(ppg_out == 0, "R9 idle low", ppg_out, 0);
      start = 1; pin_in = 1; cyc(9);
      ppg_hi = 0; cyc(24);
      chk(ppg_hi == 12, "R7 duty", ppg_hi, 12);

      phase = "R9 stop";
      idle_lvl = 1; start = 0; cyc(1);
      chk(ppg_out == 1, "R9 idle high on stop", ppg_out, 1);
      cyc(2);
      chk(ppg_out == 1, "R9 idle held", ppg_out, 1);

      phase = "R2 sparse free";
      en_sparse = 1; mode_sel = 3'd0; cmp_a = 16'd2; start = 1; cyc(40);
      phase = "R8 sparse capture";
      cmp_a = 16'd50; cyc(5); snap(); cyc(4);
      phase = "R7 sparse ppg";
      start = 0; mode_sel = 3'd4; idle_lvl = 0; pin_in = 0; cmp_a = 16'd4;
      ld_b(16'd1); cyc(4);
      start = 1; pin_in = 1; cyc(60);
      phase = "R6 sparse measure";
      start = 0; mode_sel = 3'd3; pin_in = 0; cyc(4);
      start = 1; pin_in = 1; cyc(12); pin_in = 0; cyc(8);
      phase = "R9 unused code";
      mode_sel = 3'd6; pin_in = 1; cyc(10);

      summary();
      $finish;
   end
endmodule